// File: doc/BRIEF.md
# Branch and Set Addressing Mode Unit

This unit is the execute step for two register-to-register branch operations that can also switch the processor between a 24-bit and a 31-bit addressing mode. The linking call form saves the low 32-bit half of the status word into the first register. That half holds the mode flag and the already-advanced next address. The mode-returning form only stamps the current mode flag into the top bit of the first register. Both forms take the new mode and branch target from the second register. A second-register field of zero means no branch and no mode change.

Decode supplies an operation strobe, a one-bit kind select (0 = linking call, 1 = mode return), the two 4-bit register fields and the values already read from the register file. It also supplies the low status word: bit 31 is the mode flag (1 = 31-bit, 0 = 24-bit) and bits 30:0 are the next instruction address. One cycle after the strobe, the unit raises `done` for one cycle. Its result registers then hold the new mode, the new address, a write-back value with its enable, a taken flag and a trace-event flag until the next operation. All results come from the register values as read, so an operation whose two fields name the same register still branches on the old contents.

The control is a two-state machine. `ST_IDLE` waits for a strobe. `ST_DONE` marks the cycle after a strobe, when the results are fresh. The transitions are:
- IDLE→DONE on a strobe.
- DONE→DONE on a back-to-back strobe.
- DONE→IDLE when no strobe arrives.

Top module: `brmode_unit`

## Requirements
- R1: For kind 0 (linking), wb_en is 1 and wb_data equals the full 32-bit psw_low, whatever the second field is.
- R2: When r2_field is nonzero, new_mode equals bit 31 of r2_data and taken is 1.
- R3: When r2_field is nonzero, the target follows the new mode. If bit 31 of r2_data is 1, new_addr is {1'b0, r2_data[30:0]}. If it is 0, new_addr is {8'h00, r2_data[23:0]}.
- R4: When r2_field is zero, taken is 0, new_mode equals psw_low[31] and new_addr equals {1'b0, psw_low[30:0]}.
- R5: For kind 1 (return) with r1_field nonzero, wb_en is 1 and wb_data is {psw_low[31], r1_data[30:0]}.
- R6: For kind 1 with r1_field zero, wb_en is 0.
- R7: When r1_field equals r2_field, the mode and target come from the read value r2_data and not from the write-back value.
- R8: trace_evt is 1 only for kind 0 with r2_field nonzero; it is 0 in every other case.
- R9: done is 1 exactly in the cycle after a cycle with op_valid high. All result outputs keep their values while op_valid is low.
- R10: After reset, done, new_mode, new_addr, wb_en, wb_data, taken and trace_evt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 1 | 0 = linking call, 1 = mode return |
| r1_field | input | 4 | First register field |
| r2_field | input | 4 | Second register field |
| r1_data | input | 32 | Value read from the first register |
| r2_data | input | 32 | Value read from the second register |
| psw_low | input | 32 | Low status word: mode in bit 31, next address below |
| done | output | 1 | Result valid pulse |
| new_mode | output | 1 | New addressing-mode flag |
| new_addr | output | 32 | New instruction address |
| wb_en | output | 1 | First-register write enable |
| wb_data | output | 32 | First-register write value |
| taken | output | 1 | Branch taken |
| trace_evt | output | 1 | Trace event request |

## Verification
The assertions check on every cycle that a strobe is followed by `done` and that no strobe is followed by no `done`. They also check, for each strobe, the mode source, the link word, write suppression on a zero first field in the return form, the upper-zero target in 24-bit mode and the absence of trace in the return form. Only the bench scenarios show the full target values in both modes, the same-register case and the holding of results across idle cycles. The bench also shows the reset values and back-to-back strobes whose results replace one another.

// File: rtl/brmode_pkg.sv
package brmode_pkg;

    localparam int BRM_XLEN = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } brm_state_e;

    typedef enum logic {
        OP_LINK = 1'b0,
        OP_RET  = 1'b1
    } brm_op_e;

    typedef struct packed {
        logic                mode;
        logic [BRM_XLEN-1:0] addr;
        logic                wb_en;
        logic [BRM_XLEN-1:0] wb_data;
        logic                taken;
        logic                trace;
    } brm_result_t;

endpackage

// File: rtl/brmode_target.sv
module brmode_target
    import brmode_pkg::*;
#(
    parameter int XLEN     = BRM_XLEN,
    parameter int NARROW_W = 24
) (
    input  logic [XLEN-1:0] reg_val,
    output logic [XLEN-1:0] target
);
    localparam int MSB    = XLEN - 1;
    localparam int PAD_W  = XLEN - NARROW_W;

    // The mode flag carried in the register picks how its address bits are read.
    always_comb begin
        if (reg_val[MSB]) begin
            target = {1'b0, reg_val[MSB-1:0]};
        end else begin
            target = {{PAD_W{1'b0}}, reg_val[NARROW_W-1:0]};
        end
    end
endmodule

// File: rtl/brmode_result.sv
module brmode_result
    import brmode_pkg::*;
#(
    parameter int XLEN      = BRM_XLEN,
    parameter int REG_IDX_W = 4,
    parameter int NARROW_W  = 24
) (
    input  logic                 op_kind,
    input  logic [REG_IDX_W-1:0] r1_field,
    input  logic [REG_IDX_W-1:0] r2_field,
    input  logic [XLEN-1:0]      r1_data,
    input  logic [XLEN-1:0]      r2_data,
    input  logic [XLEN-1:0]      psw_low,
    output brm_result_t          res
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] br_target;
    logic            r1_used;
    logic            r2_used;
    brm_op_e         kind;

    assign kind    = brm_op_e'(op_kind);
    assign r1_used = (r1_field != '0);
    assign r2_used = (r2_field != '0);

    brmode_target #(
        .XLEN     (XLEN),
        .NARROW_W (NARROW_W)
    ) u_tgt (
        .reg_val (r2_data),
        .target  (br_target)
    );

    // Mode and target come only from the read value of the second register (R7).
    always_comb begin
        res = '0;
        if (r2_used) begin
            res.mode  = r2_data[MSB];
            res.addr  = br_target;
            res.taken = 1'b1;
        end else begin
            res.mode  = psw_low[MSB];
            res.addr  = {1'b0, psw_low[MSB-1:0]};
            res.taken = 1'b0;
        end
        unique case (kind)
            OP_LINK: begin
                res.wb_en   = 1'b1;
                res.wb_data = psw_low;
                res.trace   = r2_used;
            end
            OP_RET: begin
                res.wb_en        = r1_used;
                res.wb_data      = r1_data;
                res.wb_data[MSB] = psw_low[MSB];
                res.trace        = 1'b0;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/brmode_unit.sv
module brmode_unit
    import brmode_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    parameter int NARROW_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic                 op_kind,
    input  logic [REG_IDX_W-1:0] r1_field,
    input  logic [REG_IDX_W-1:0] r2_field,
    input  logic [BRM_XLEN-1:0]  r1_data,
    input  logic [BRM_XLEN-1:0]  r2_data,
    input  logic [BRM_XLEN-1:0]  psw_low,
    output logic                 done,
    output logic                 new_mode,
    output logic [BRM_XLEN-1:0]  new_addr,
    output logic                 wb_en,
    output logic [BRM_XLEN-1:0]  wb_data,
    output logic                 taken,
    output logic                 trace_evt
);
    localparam int XLEN = BRM_XLEN;

    brm_state_e  state_q;
    brm_state_e  state_d;
    brm_result_t next_res;
    brm_result_t res_q;

    brmode_result #(
        .XLEN      (XLEN),
        .REG_IDX_W (REG_IDX_W),
        .NARROW_W  (NARROW_W)
    ) u_res (
        .op_kind  (op_kind),
        .r1_field (r1_field),
        .r2_field (r2_field),
        .r1_data  (r1_data),
        .r2_data  (r2_data),
        .psw_low  (psw_low),
        .res      (next_res)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_DONE;
            ST_DONE: state_d = op_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers: loaded on a strobe, held otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (op_valid) begin
            res_q <= next_res;
        end
    end

    assign done      = (state_q == ST_DONE);
    assign new_mode  = res_q.mode;
    assign new_addr  = res_q.addr;
    assign wb_en     = res_q.wb_en;
    assign wb_data   = res_q.wb_data;
    assign taken     = res_q.taken;
    assign trace_evt = res_q.trace;
endmodule

// File: rtl/brmode_chk.sv
module brmode_chk
    import brmode_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    parameter int NARROW_W  = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic                 op_kind,
    input logic [REG_IDX_W-1:0] r1_field,
    input logic [REG_IDX_W-1:0] r2_field,
    input logic [BRM_XLEN-1:0]  r2_data,
    input logic [BRM_XLEN-1:0]  psw_low,
    input logic                 done,
    input logic                 new_mode,
    input logic [BRM_XLEN-1:0]  new_addr,
    input logic                 wb_en,
    input logic [BRM_XLEN-1:0]  wb_data,
    input logic                 taken,
    input logic                 trace_evt
);
    localparam int MSB = BRM_XLEN - 1;

    a_r1_link_word: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_kind) |=> (wb_en && wb_data == $past(psw_low)));

    a_r2_mode_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && r2_field != '0) |=> (taken && new_mode == $past(r2_data[MSB])));

    a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && r2_field != '0 && !r2_data[MSB])
            |=> (new_addr[MSB:NARROW_W] == '0));

    a_r4_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && r2_field == '0) |=> (!taken && new_mode == $past(psw_low[MSB])));

    a_r6_no_write_r0: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind && r1_field == '0) |=> !wb_en);

    a_r8_no_trace_return: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind) |=> !trace_evt);

    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);
endmodule

bind brmode_unit brmode_chk #(
    .REG_IDX_W (REG_IDX_W),
    .NARROW_W  (NARROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .r1_field  (r1_field),
    .r2_field  (r2_field),
    .r2_data   (r2_data),
    .psw_low   (psw_low),
    .done      (done),
    .new_mode  (new_mode),
    .new_addr  (new_addr),
    .wb_en     (wb_en),
    .wb_data   (wb_data),
    .taken     (taken),
    .trace_evt (trace_evt)
);

// File: tb/sim_brmode_unit.sv
module sim_brmode_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct packed {
        logic        kind;
        logic [3:0]  r1f;
        logic [3:0]  r2f;
        logic [31:0] r1d;
        logic [31:0] r2d;
        logic [31:0] psw;
        logic        e_mode;
        logic [31:0] e_addr;
        logic        e_wben;
        logic [31:0] e_wbd;
        logic        e_taken;
        logic        e_trace;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // link, branch into 31-bit mode
        '{1'b0, 4'd3, 4'd5, 32'h0000_0000, 32'h8123_4567, 32'h0000_1004,
          1'b1, 32'h0123_4567, 1'b1, 32'h0000_1004, 1'b1, 1'b1},
        // link, branch down into 24-bit mode
        '{1'b0, 4'd1, 4'd6, 32'hDEAD_BEEF, 32'h12AB_CDEF, 32'h8000_2000,
          1'b0, 32'h00AB_CDEF, 1'b1, 32'h8000_2000, 1'b1, 1'b1},
        // link, R2 field zero: no branch, link still written
        '{1'b0, 4'd2, 4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8040_0010,
          1'b1, 32'h0040_0010, 1'b1, 32'h8040_0010, 1'b0, 1'b0},
        // return, mode bit inserted into R1
        '{1'b1, 4'd14, 4'd2, 32'h7FFF_FFFF, 32'h0000_4000, 32'h8000_0100,
          1'b0, 32'h0000_4000, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0},
        // return, R1 field zero: no write
        '{1'b1, 4'd0, 4'd7, 32'h1234_5678, 32'h9000_0000, 32'h0000_0200,
          1'b1, 32'h1000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b0},
        // return, both fields zero
        '{1'b1, 4'd0, 4'd0, 32'h5555_5555, 32'hAAAA_AAAA, 32'h0012_3456,
          1'b0, 32'h0012_3456, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        // return, same register: target from old value
        '{1'b1, 4'd9, 4'd9, 32'h0000_8000, 32'h0000_8000, 32'h8000_0400,
          1'b0, 32'h0000_8000, 1'b1, 32'h8000_8000, 1'b1, 1'b0},
        // link, same register: target from old value
        '{1'b0, 4'd4, 4'd4, 32'h8765_4321, 32'h8765_4321, 32'h0000_0040,
          1'b1, 32'h0765_4321, 1'b1, 32'h0000_0040, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [3:0]  r1_field = '0;
    logic [3:0]  r2_field = '0;
    logic [31:0] r1_data = '0;
    logic [31:0] r2_data = '0;
    logic [31:0] psw_low = '0;
    logic        done;
    logic        new_mode;
    logic [31:0] new_addr;
    logic        wb_en;
    logic [31:0] wb_data;
    logic        taken;
    logic        trace_evt;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brmode_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .r1_field  (r1_field),
        .r2_field  (r2_field),
        .r1_data   (r1_data),
        .r2_data   (r2_data),
        .psw_low   (psw_low),
        .done      (done),
        .new_mode  (new_mode),
        .new_addr  (new_addr),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .taken     (taken),
        .trace_evt (trace_evt)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_kind  = v.kind;
        r1_field = v.r1f;
        r2_field = v.r2f;
        r1_data  = v.r1d;
        r2_data  = v.r2d;
        psw_low  = v.psw;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string t;
        t = $sformatf("vec%0d", idx);
        check("R9", {t, " done"}, {31'd0, done}, 32'd1);
        check("R2/R4", {t, " new_mode"}, {31'd0, new_mode}, {31'd0, v.e_mode});
        check("R3/R4/R7", {t, " new_addr"}, new_addr, v.e_addr);
        check("R1/R5/R6", {t, " wb_en"}, {31'd0, wb_en}, {31'd0, v.e_wben});
        if (v.e_wben) check("R1/R5/R7", {t, " wb_data"}, wb_data, v.e_wbd);
        check("R2/R4", {t, " taken"}, {31'd0, taken}, {31'd0, v.e_taken});
        check("R8", {t, " trace_evt"}, {31'd0, trace_evt}, {31'd0, v.e_trace});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R10: reset values
        repeat (3) @(negedge clk);
        check("R10", "done", {31'd0, done}, 32'd0);
        check("R10", "new_mode", {31'd0, new_mode}, 32'd0);
        check("R10", "new_addr", new_addr, 32'd0);
        check("R10", "wb_en", {31'd0, wb_en}, 32'd0);
        check("R10", "wb_data", wb_data, 32'd0);
        check("R10", "taken/trace", {30'd0, taken, trace_evt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            check_vec(VECS[i], i);
            @(negedge clk);
            check("R9", $sformatf("vec%0d done drops", i), {31'd0, done}, 32'd0);
        end

        // R9: results held while idle, inputs changing
        drive(VECS[0]);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        drive(VECS[5]);
        repeat (4) @(negedge clk);
        check("R9", "hold new_addr", new_addr, 32'h0123_4567);
        check("R9", "hold wb_data", wb_data, 32'h0000_1004);
        check("R9", "hold trace", {31'd0, trace_evt}, 32'd1);
        check("R9", "idle done", {31'd0, done}, 32'd0);

        // R9: back-to-back strobes, second replaces first
        drive(VECS[1]);
        op_valid = 1'b1;
        @(negedge clk);
        check("R9", "b2b first addr", new_addr, 32'h00AB_CDEF);
        drive(VECS[3]);
        @(negedge clk);
        op_valid = 1'b0;
        check("R9", "b2b done held", {31'd0, done}, 32'd1);
        check("R5", "b2b second wb_data", wb_data, 32'hFFFF_FFFF);
        check("R8", "b2b second trace", {31'd0, trace_evt}, 32'd0);
        @(negedge clk);

        // R3: 24-bit target with every high bit set in the register
        op_kind = 1'b0; r1_field = 4'd8; r2_field = 4'd15;
        r2_data = 32'h7FFF_FFFF; psw_low = 32'h8000_0000;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check("R3", "narrow mask", new_addr, 32'h00FF_FFFF);
        check("R2", "mode down", {31'd0, new_mode}, 32'd0);

        // R10: reset in the middle clears results
        drive(VECS[7]);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R10", "async reset addr", new_addr, 32'd0);
        check("R10", "async reset done", {31'd0, done}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end
endmodule